// File: doc/BRIEF.md
# Two-Wire Register Bank Slave with Auto-Incrementing Pointer

This block is a serial two-wire bus slave. It gives a bus master access to a bank of 8-bit registers through one internal pointer. The block works in a fast system clock domain. It brings the bus clock and data lines in through synchronizers. It finds START and STOP conditions and collects the 7-bit device address and the direction bit. It acknowledges each byte by pulling the data line low through an open-drain enable.

The master can use three kinds of transfer:
- A short write of only a command byte. It moves the pointer and changes no register.
- A write of a command byte followed by any number of data bytes. Each data byte goes to the pointer location, and the pointer then advances.
- A read. It returns bytes from the pointer onward, one byte for each master acknowledge.

The pointer is checked against a fixed top address and wraps to zero after the top register. A STOP condition leaves the pointer unchanged. A local port lets neighbouring logic read any register directly.

Top module: `twiRegSlave`

## Requirements
- R1: After the active-low synchronous reset, every register reads 0x00 on the local port, the pointer is 0x00 and the slave does not pull the data line.
- R2: The slave acknowledges an address byte only when its upper seven bits equal the `DEV_ADDR` parameter. Bit 0 is the direction bit: 0 means write and 1 means read. On a mismatch the slave never pulls the data line until the next START or STOP, so every later byte of that transfer sees a NACK.
- R3: A write transfer that ends with STOP right after the acknowledged command byte loads the pointer from that byte and writes no register.
- R4: In a write transfer, each data byte after the command byte is acknowledged and stored at the pointer, and the pointer then advances by one.
- R5: A command byte above `TOP_REG` (0x45 by default) gets a NACK. It does not change the pointer, and the data bytes that follow it are neither acknowledged nor written.
- R6: When the pointer advances from `TOP_REG`, it becomes 0x00. This holds for writes and for reads.
- R7: A STOP condition does not change the pointer. A read that follows starts at the last pointer value that was set or reached.
- R8: In a read, the slave shifts out the register at the pointer, most significant bit first, and advances the pointer. A master ACK starts the next byte. After a master NACK the slave leaves the data line released.
- R9: A repeated START in the middle of a byte drops the partial byte and restarts address reception. The pointer is not changed.
- R10: The slave changes its data-line drive only while the synchronized bus clock is low.
- R11: The local read port `rdAddr`/`rdData` returns the register content combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | Open-drain enable; 1 pulls the data line low |
| rdAddr | input | 7 | Local read-back register index |
| rdData | output | 8 | Local read-back register content |

## Verification
A wrong pointer shows up at the ports one transfer later, as the wrong byte in the next read or a store to the wrong index on the local read port. The bench therefore follows every pointer-moving sequence with a read or a read-back. A wrong FSM state shows up within one acknowledge slot, as a missing or extra pull on the data line. Each byte's acknowledge level is checked at the rising bus clock edge of that slot. The data-line drive is also watched at every change, so that any change made while the bus clock is high is caught in the cycle it happens.

// File: rtl/twiRegPkg.sv
package twiRegPkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK, ST_IGNORE
  } twiState_t;

  // bus events seen by the datapath, handed to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaBit;
  } busEvents_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic clrBits;
    logic loadPtr;
    logic wrReg;
    logic loadTx;
    logic nextTx;
    logic pullAck;
    logic relSda;
  } ctrlStrobes_t;
endpackage

// File: rtl/twiDatapath.sv
module twiDatapath
  import twiRegPkg::*;
#(
  parameter int TOP_REG  = 69,
  parameter int SYNC_LEN = 2,
  localparam int NUM_REGS = TOP_REG + 1,
  localparam int PTR_W    = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  ctrlStrobes_t       strb,
  output busEvents_t         ev,
  output logic [BYTE_W-1:0]  rxByte,
  output logic [CNT_W-1:0]   bitCnt,
  output logic               sdaOe,
  input  logic [PTR_W-1:0]   rdAddr,
  output logic [BYTE_W-1:0]  rdData
);
  logic [SYNC_LEN:0]   sclQ, sdaQ;
  logic                sclS, sclP, sdaS, sdaP;
  logic [PTR_W-1:0]    ptr;
  logic [BYTE_W-1:0]   txByte;
  logic [BYTE_W-1:0]   regs [NUM_REGS];

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(TOP_REG)) ? '0 : p + 1'b1;
  endfunction

  // input synchronizers plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= '1;
      sdaQ <= '1;
    end else begin
      sclQ <= {sclQ[SYNC_LEN-1:0], sclIn};
      sdaQ <= {sdaQ[SYNC_LEN-1:0], sdaIn};
    end
  end

  assign sclS = sclQ[SYNC_LEN-1];
  assign sclP = sclQ[SYNC_LEN];
  assign sdaS = sdaQ[SYNC_LEN-1];
  assign sdaP = sdaQ[SYNC_LEN];

  always_comb begin
    ev.sclRise   = sclS & ~sclP;
    ev.sclFall   = ~sclS & sclP;
    ev.startSeen = sclS & sclP & sdaP & ~sdaS;
    ev.stopSeen  = sclS & sclP & ~sdaP & sdaS;
    ev.sdaBit    = sdaS;
  end

  // receive shifter and bit counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte <= '0;
      bitCnt <= '0;
    end else begin
      if (strb.shiftIn) rxByte <= {rxByte[BYTE_W-2:0], sdaS};
      if (strb.clrBits || strb.loadTx) bitCnt <= '0;
      else if (strb.shiftIn || strb.nextTx) bitCnt <= bitCnt + 1'b1;
    end
  end

  // pointer and register bank
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (strb.loadPtr) begin
      ptr <= rxByte[PTR_W-1:0];
    end else if (strb.wrReg) begin
      regs[ptr] <= rxByte;
      ptr       <= bumpPtr(ptr);
    end else if (strb.loadTx) begin
      ptr <= bumpPtr(ptr);
    end
  end

  // transmit shifter and open-drain drive
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txByte <= '0;
      sdaOe  <= 1'b0;
    end else if (strb.relSda) begin
      sdaOe <= 1'b0;
    end else if (strb.pullAck) begin
      sdaOe <= 1'b1;
    end else if (strb.loadTx) begin
      txByte <= regs[ptr];
      sdaOe  <= ~regs[ptr][BYTE_W-1];
    end else if (strb.nextTx) begin
      txByte <= {txByte[BYTE_W-2:0], 1'b0};
      sdaOe  <= ~txByte[BYTE_W-2];
    end
  end

  assign rdData = (rdAddr <= PTR_W'(TOP_REG)) ? regs[rdAddr] : '0;

  // R10
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS);
  // R6
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= PTR_W'(TOP_REG));
  // R6
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.wrReg || strb.loadTx) && ptr == PTR_W'(TOP_REG)) |=> ptr == '0);
  // R5
  cmd_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPtr |-> rxByte <= BYTE_W'(TOP_REG));
endmodule

// File: rtl/twiCtrl.sv
module twiCtrl
  import twiRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         TOP_REG  = 69
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvents_t        ev,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [CNT_W-1:0]  bitCnt,
  output ctrlStrobes_t      strb
);
  twiState_t st, nxt;
  logic      isRead, mAck;
  logic      byteFull, addrHit, cmdOk;

  assign byteFull = (bitCnt == CNT_W'(BYTE_W));
  assign addrHit  = (rxByte[BYTE_W-1:1] == DEV_ADDR);
  assign cmdOk    = (rxByte <= BYTE_W'(TOP_REG));

  always_comb begin
    strb = '0;
    nxt  = st;
    if (ev.stopSeen) begin
      nxt          = ST_IDLE;
      strb.relSda  = 1'b1;
      strb.clrBits = 1'b1;
    end else if (ev.startSeen) begin
      nxt          = ST_ADDR;
      strb.relSda  = 1'b1;
      strb.clrBits = 1'b1;
    end else begin
      case (st)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (ev.sclRise && !byteFull) strb.shiftIn = 1'b1;
          if (ev.sclFall && byteFull) begin
            strb.clrBits = 1'b1;
            if (st == ST_ADDR) begin
              if (addrHit) begin
                strb.pullAck = 1'b1;
                nxt          = ST_ADDR_ACK;
              end else begin
                nxt = ST_IGNORE;
              end
            end else if (st == ST_CMD) begin
              if (cmdOk) begin
                strb.pullAck = 1'b1;
                strb.loadPtr = 1'b1;
                nxt          = ST_CMD_ACK;
              end else begin
                nxt = ST_IGNORE;
              end
            end else begin
              strb.pullAck = 1'b1;
              strb.wrReg   = 1'b1;
              nxt          = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (ev.sclFall) begin
            if (isRead) begin
              strb.loadTx = 1'b1;
              nxt         = ST_RDATA;
            end else begin
              strb.relSda = 1'b1;
              nxt         = ST_CMD;
            end
          end
        end
        ST_CMD_ACK, ST_WDATA_ACK: begin
          if (ev.sclFall) begin
            strb.relSda = 1'b1;
            nxt         = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (ev.sclFall) begin
            if (bitCnt == CNT_W'(BYTE_W - 1)) begin
              strb.relSda  = 1'b1;
              strb.clrBits = 1'b1;
              nxt          = ST_RACK;
            end else begin
              strb.nextTx = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (ev.sclFall) begin
            if (mAck) begin
              strb.loadTx = 1'b1;
              nxt         = ST_RDATA;
            end else begin
              nxt = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      isRead <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      st <= nxt;
      if (st == ST_ADDR && ev.sclFall && byteFull) isRead <= rxByte[0];
      if (st == ST_RACK && ev.sclRise) mAck <= ~ev.sdaBit;
    end
  end

  // R2
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IGNORE) |-> !(strb.pullAck || strb.loadTx || strb.wrReg));
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrReg, strb.loadPtr, strb.loadTx}));
endmodule

// File: rtl/twiRegSlave.sv
module twiRegSlave
  import twiRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         TOP_REG  = 69,
  parameter int         SYNC_LEN = 2,
  localparam int        PTR_W    = $clog2(TOP_REG + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [PTR_W-1:0]  rdAddr,
  output logic [BYTE_W-1:0] rdData
);
  busEvents_t        ev;
  ctrlStrobes_t      strb;
  logic [BYTE_W-1:0] rxByte;
  logic [CNT_W-1:0]  bitCnt;

  twiCtrl #(.DEV_ADDR(DEV_ADDR), .TOP_REG(TOP_REG)) ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte), .bitCnt(bitCnt), .strb(strb)
  );

  twiDatapath #(.TOP_REG(TOP_REG), .SYNC_LEN(SYNC_LEN)) dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .ev(ev), .rxByte(rxByte), .bitCnt(bitCnt), .sdaOe(sdaOe),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/twiRegSlave_test.sv
module twiRegSlave_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ADDR_W = 8'h54;
  localparam logic [7:0] ADDR_R = 8'h55;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scl = 1'b1;
  logic       mSda = 1'b1;
  logic       sdaOe;
  logic [6:0] rdAddr = '0;
  logic [7:0] rdData;
  wire        sdaLine = mSda & ~sdaOe;
  int checks = 0;
  int errors = 0;
  int r10Bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twiRegSlave uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .rdAddr(rdAddr), .rdData(rdData)
  );

  // R10 monitor: drive changes only while the bus clock is low
  always @(sdaOe) if (rstN && scl) r10Bad++;

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic peek(input string tag, input logic [6:0] a, input logic [7:0] exp);
    rdAddr = a;
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic startBus();
    mSda = 1'b1; waitClk(10);
    scl = 1'b1;  waitClk(20);
    mSda = 1'b0; waitClk(20);
    scl = 1'b0;  waitClk(10);
  endtask

  task automatic stopBus();
    mSda = 1'b0; waitClk(10);
    scl = 1'b1;  waitClk(20);
    mSda = 1'b1; waitClk(20);
  endtask

  task automatic bitOut(input logic v);
    mSda = v;   waitClk(10);
    scl = 1'b1; waitClk(20);
    scl = 1'b0; waitClk(10);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) bitOut(b[i]);
    mSda = 1'b1; waitClk(10);
    scl = 1'b1;  waitClk(10);
    acked = ~sdaLine;
    waitClk(10);
    scl = 1'b0;  waitClk(10);
  endtask

  task automatic readByte(output logic [7:0] v, input logic giveAck);
    v = '0;
    mSda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      waitClk(10); scl = 1'b1;
      waitClk(10); v = {v[6:0], sdaLine};
      waitClk(10); scl = 1'b0;
    end
    waitClk(2);
    mSda = giveAck ? 1'b0 : 1'b1;
    waitClk(8); scl = 1'b1;
    waitClk(20); scl = 1'b0;
    waitClk(10); mSda = 1'b1;
  endtask

  task automatic sendAck(input string tag, input logic [7:0] b, input logic expAck);
    logic a;
    sendByte(b, a);
    chk(tag, {7'd0, a}, {7'd0, expAck});
  endtask

  task automatic testReset();
    peek("R1 reg 0x00 after reset", 7'h00, 8'h00);
    peek("R1 reg 0x45 after reset", 7'h45, 8'h00);
    chk("R1 data line released", {7'd0, sdaOe}, 8'h00);
  endtask

  task automatic testBurstWrite();
    startBus();
    sendAck("R2 own address acked", ADDR_W, 1'b1);
    sendAck("R4 command acked", 8'h10, 1'b1);
    sendAck("R4 data 0 acked", 8'hA1, 1'b1);
    sendAck("R4 data 1 acked", 8'hB2, 1'b1);
    sendAck("R4 data 2 acked", 8'hC3, 1'b1);
    sendAck("R4 data 3 acked", 8'hD4, 1'b1);
    stopBus();
    peek("R4 R11 reg 0x10", 7'h10, 8'hA1);
    peek("R4 reg 0x11", 7'h11, 8'hB2);
    peek("R4 reg 0x13", 7'h13, 8'hD4);
  endtask

  task automatic testSendRead();
    logic [7:0] v;
    startBus();
    sendAck("R3 address acked", ADDR_W, 1'b1);
    sendAck("R3 pointer byte acked", 8'h11, 1'b1);
    stopBus();
    peek("R3 no register written", 7'h11, 8'hB2);
    startBus();
    sendAck("R8 read address acked", ADDR_R, 1'b1);
    readByte(v, 1'b1);
    chk("R8 first byte from pointer", v, 8'hB2);
    readByte(v, 1'b0);
    chk("R8 next byte after master ack", v, 8'hC3);
    chk("R8 released after master nack", {7'd0, sdaOe}, 8'h00);
    stopBus();
  endtask

  task automatic testStopKeeps();
    logic [7:0] v;
    startBus();
    sendAck("R7 read address acked", ADDR_R, 1'b1);
    readByte(v, 1'b0);
    stopBus();
    chk("R7 read resumes at pointer", v, 8'hD4);
  endtask

  task automatic testBadCmd();
    logic [7:0] v;
    startBus();
    sendAck("R5 address acked", ADDR_W, 1'b1);
    sendAck("R5 command 0x20 acked", 8'h20, 1'b1);
    sendAck("R5 data acked", 8'h66, 1'b1);
    stopBus();
    startBus();
    sendAck("R5 address acked", ADDR_W, 1'b1);
    sendAck("R5 pointer 0x20 acked", 8'h20, 1'b1);
    stopBus();
    startBus();
    sendAck("R5 address acked", ADDR_W, 1'b1);
    sendAck("R5 command 0x46 nacked", 8'h46, 1'b0);
    sendAck("R5 data after bad command nacked", 8'h77, 1'b0);
    stopBus();
    peek("R5 reg 0x20 untouched", 7'h20, 8'h66);
    peek("R5 reg 0x21 untouched", 7'h21, 8'h00);
    startBus();
    sendAck("R5 read address acked", ADDR_R, 1'b1);
    readByte(v, 1'b0);
    stopBus();
    chk("R5 pointer unchanged", v, 8'h66);
  endtask

  task automatic testWrap();
    logic [7:0] v;
    startBus();
    sendAck("R6 address acked", ADDR_W, 1'b1);
    sendAck("R6 top command 0x45... 0x44 acked", 8'h44, 1'b1);
    sendAck("R6 data 0x44", 8'h01, 1'b1);
    sendAck("R6 data 0x45", 8'h02, 1'b1);
    sendAck("R6 data wraps", 8'h03, 1'b1);
    stopBus();
    peek("R6 reg 0x45", 7'h45, 8'h02);
    peek("R6 write wrapped to 0x00", 7'h00, 8'h03);
    startBus();
    sendAck("R6 address acked", ADDR_W, 1'b1);
    sendAck("R6 command 0x45 acked", 8'h45, 1'b1);
    stopBus();
    startBus();
    sendAck("R6 read address acked", ADDR_R, 1'b1);
    readByte(v, 1'b1);
    chk("R6 read at top", v, 8'h02);
    readByte(v, 1'b0);
    chk("R6 read wrapped to 0x00", v, 8'h03);
    stopBus();
  endtask

  task automatic testMismatch();
    startBus();
    sendAck("R2 foreign address nacked", 8'h56, 1'b0);
    sendAck("R2 command ignored", 8'h00, 1'b0);
    sendAck("R2 data ignored", 8'hEE, 1'b0);
    stopBus();
    peek("R2 reg 0x00 untouched", 7'h00, 8'h03);
  endtask

  task automatic testRepStart();
    logic [7:0] v;
    startBus();
    sendAck("R9 address acked", ADDR_W, 1'b1);
    sendAck("R9 command acked", 8'h30, 1'b1);
    sendAck("R9 data acked", 8'h3C, 1'b1);
    stopBus();
    startBus();
    sendAck("R9 address acked", ADDR_W, 1'b1);
    sendAck("R9 pointer 0x30 acked", 8'h30, 1'b1);
    stopBus();
    startBus();
    sendAck("R9 address acked", ADDR_W, 1'b1);
    bitOut(1'b0); bitOut(1'b1); bitOut(1'b0); bitOut(1'b1);
    startBus();
    sendAck("R9 read after repeated start acked", ADDR_R, 1'b1);
    readByte(v, 1'b0);
    stopBus();
    chk("R9 pointer kept across abort", v, 8'h3C);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    testReset();
    testBurstWrite();
    testSendRead();
    testStopKeeps();
    testBadCmd();
    testWrap();
    testMismatch();
    testRepStart();
    chk("R10 drive changes with clock high", r10Bad[7:0], 8'h00);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule